// File: doc/BRIEF.md
# Multiprocessor Firmware Control Register Block

This block sits on a simple word-wide register bus and gives boot firmware a handful of system controls on a multiprocessor chip. A store to the halt register raises a one-cycle halt request that carries an exit status byte. Two read-only registers report which processor issued the access and how many processors are active. A fourth register lets firmware drive a held level onto any one of the per-processor interrupt lines, so that one processor can interrupt another through its level-sensitive external interrupt input.

The bus carries a byte address, a write flag, a word of write data and one enable per byte lane. Lane 0 (bits 7:0) holds the byte at the lowest address of the word, lane 1 (bits 15:8) the next one, and so on. Only the low six address bits are decoded. The word index `addr[5:2]` selects the register: 0 halt, 1 requester ID, 2 interrupt control, 3 processor count. `addr[1:0]` and all bits above bit 5 are ignored.

Reads are answered one cycle after the request by a two-state sequencer. In `ST_IDLE` the response is inactive. The transition `idle_to_resp` is taken when a read is presented. In `ST_RESP` the response is valid. From there, `resp_to_resp` is taken when another read follows straight away, and `resp_to_idle` is taken otherwise. `ST_IDLE` stays put on writes and on idle cycles (`idle_hold`).

Top module: `fw_ctrl_regs`

## Requirements
- R1: After reset every interrupt line is 0, `halt_strobe` is 0 and `resp_valid` is 0.
- R2: A write at word index 0 with lane 0 enabled raises `halt_strobe` for exactly one cycle, in the cycle after the request, with `halt_status` equal to write byte 0. If lane 0 is not enabled, no strobe is raised.
- R3: A read at word index 1 returns the `req_cpu_id` sampled in the request cycle in bits 7:0, with all other bits zero.
- R4: A read at word index 3 returns the `CPU_COUNT` parameter in bits 7:0, or 1 when `CPU_COUNT` is 0, with all other bits zero.
- R5: A write at word index 2 with lanes 0 and 1 enabled sets line `wdata[7:0]` to 1 if `wdata[15:8]` is nonzero and to 0 otherwise. The new value is visible the cycle after the request, and all other lines keep their values.
- R6: A write at word index 2 with lane 0 enabled and lane 1 disabled drives the selected line to 0.
- R7: An interrupt write whose line index is `NCPU` or greater, or whose lane 0 is disabled, leaves all lines unchanged.
- R8: Address bits above bit 5 are ignored, so the block repeats every 64 bytes.
- R9: Reads at word indices 0, 2 and 4 to 15 return zero. Writes at word indices 1 and 3 to 15 change neither the lines nor `halt_strobe`.
- R10: `resp_valid` is 1 exactly in the cycle after a read request (states `ST_IDLE`/`ST_RESP`), so back-to-back reads give back-to-back responses, and writes give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte-lane enables, lane 0 = lowest address |
| req_wdata | input | DATA_W | Write data |
| req_cpu_id | input | 8 | Index of the processor issuing the request |
| resp_valid | output | 1 | Read data valid |
| resp_rdata | output | DATA_W | Read data |
| halt_strobe | output | 1 | One-cycle halt request |
| halt_status | output | 8 | Exit status of the last halt request |
| irq_out | output | NCPU | Held interrupt level, one line per processor |

## Verification
The hardest thing to show from the ports is that a write leaves lines alone. A line that was never set looks exactly like a line that was cleared. So the bench first builds a mixed pattern of set and clear lines with two-byte stores. Then it sends out-of-range indices, stores with lane 0 disabled, and stores to every undecoded offset and alias, and checks the whole vector after each one against a model kept in the bench. One-byte stores go to lines that were just set, so that the forced zero shows up as an actual change.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
    typedef enum logic [2:0] {
        REG_HALT,
        REG_ID,
        REG_IRQ,
        REG_COUNT,
        REG_NONE
    } fwc_reg_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } fwc_state_e;

    localparam int unsigned WIDX_W = 4;
endpackage

// File: rtl/fwc_decode.sv
module fwc_decode
    import fwc_pkg::*;
(
    input  logic [WIDX_W-1:0] widx,
    output fwc_reg_e          sel
);
    always_comb begin
        unique case (widx)
            4'd0:    sel = REG_HALT;
            4'd1:    sel = REG_ID;
            4'd2:    sel = REG_IRQ;
            4'd3:    sel = REG_COUNT;
            default: sel = REG_NONE;
        endcase
    end
endmodule

// File: rtl/fwc_irq_bank.sv
module fwc_irq_bank #(
    parameter int unsigned NCPU = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      line_idx,
    input  logic            level_on,
    output logic [NCPU-1:0] lines
);
    for (genvar k = 0; k < NCPU; k++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lines[k] <= 1'b0;
            else if (wr_en && (line_idx == 8'(k)))
                lines[k] <= level_on;
        end
    end
endmodule

// File: rtl/fwc_bus_fsm.sv
module fwc_bus_fsm
    import fwc_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              halt_go,
    input  logic [7:0]        halt_byte,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              halt_strobe,
    output logic [7:0]        halt_status
);
    fwc_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_go ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_go ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_rdata  <= '0;
            halt_strobe <= 1'b0;
            halt_status <= 8'h00;
        end else begin
            if (rd_go)
                resp_rdata <= rd_word;
            halt_strobe <= halt_go;
            if (halt_go)
                halt_status <= halt_byte;
        end
    end

    assign resp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/fw_ctrl_regs.sv
module fw_ctrl_regs
    import fwc_pkg::*;
#(
    parameter int unsigned NCPU      = 4,
    parameter int unsigned CPU_COUNT = 0,
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [7:0]            req_cpu_id,
    output logic                  resp_valid,
    output logic [DATA_W-1:0]     resp_rdata,
    output logic                  halt_strobe,
    output logic [7:0]            halt_status,
    output logic [NCPU-1:0]       irq_out
);
    localparam logic [7:0] COUNT_VAL = (CPU_COUNT == 0) ? 8'd1 : 8'(CPU_COUNT);

    fwc_reg_e          sel;
    logic              wr_go, rd_go;
    logic [DATA_W-1:0] rd_word;

    fwc_decode u_dec (
        .widx (req_addr[5:2]),
        .sel  (sel)
    );

    assign wr_go = req_valid && req_write;
    assign rd_go = req_valid && !req_write;

    always_comb begin
        rd_word = '0;
        unique case (sel)
            REG_ID:    rd_word[7:0] = req_cpu_id;
            REG_COUNT: rd_word[7:0] = COUNT_VAL;
            default:   rd_word = '0;
        endcase
    end

    fwc_irq_bank #(.NCPU(NCPU)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go && (sel == REG_IRQ) && req_be[0]),
        .line_idx (req_wdata[7:0]),
        .level_on (req_be[1] && (req_wdata[15:8] != 8'h00)),
        .lines    (irq_out)
    );

    fwc_bus_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_go       (rd_go),
        .rd_word     (rd_word),
        .halt_go     (wr_go && (sel == REG_HALT) && req_be[0]),
        .halt_byte   (req_wdata[7:0]),
        .resp_valid  (resp_valid),
        .resp_rdata  (resp_rdata),
        .halt_strobe (halt_strobe),
        .halt_status (halt_status)
    );
endmodule

// File: rtl/fwc_chk.sv
module fwc_chk #(
    parameter int unsigned NCPU   = 4,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W/8-1:0] req_be,
    input logic [DATA_W-1:0]   req_wdata,
    input logic [7:0]          req_cpu_id,
    input logic                resp_valid,
    input logic [DATA_W-1:0]   resp_rdata,
    input logic                halt_strobe,
    input logic [7:0]          halt_status,
    input logic [NCPU-1:0]     irq_out
);
    // R2
    halt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_strobe |=> !halt_strobe);

    // R2
    halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[5:2] == 4'd0 && req_be[0])
        |=> (halt_strobe && halt_status == $past(req_wdata[7:0])));

    // R3
    id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[5:2] == 4'd1)
        |=> (resp_rdata == DATA_W'($past(req_cpu_id))));

    // R7
    irq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr[5:2] == 4'd2 && req_wdata[7:0] >= 8'(NCPU))
        |=> $stable(irq_out));

    // R10
    resp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> resp_valid);

    // R10
    resp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && !req_write));
endmodule

bind fw_ctrl_regs fwc_chk #(.NCPU(NCPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_be      (req_be),
    .req_wdata   (req_wdata),
    .req_cpu_id  (req_cpu_id),
    .resp_valid  (resp_valid),
    .resp_rdata  (resp_rdata),
    .halt_strobe (halt_strobe),
    .halt_status (halt_status),
    .irq_out     (irq_out)
);

// File: tb/fw_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module fw_ctrl_regs_tb_top;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_cpu_id = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        halt_strobe;
    logic [7:0]  halt_status;
    logic [NCPU-1:0] irq_out;

    int checks = 0;
    int errors = 0;
    logic [NCPU-1:0] exp_irq = '0;
    bit done = 0;

    always #10 clk = ~clk;

    fw_ctrl_regs #(.NCPU(NCPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_cpu_id(req_cpu_id), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .halt_strobe(halt_strobe), .halt_status(halt_status), .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        req_valid = 0; req_write = 0; req_be = '0; req_wdata = '0;
    endtask

    // Issue a write at a negedge; outputs are checked at the following negedge.
    task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] id, input logic [31:0] exp, input string req);
        req_valid = 1; req_write = 0; req_addr = a; req_cpu_id = id;
        @(negedge clk);
        idle_bus();
        req_cpu_id = 8'hEE;
        chk(resp_valid === 1'b1, "R10 read response valid", 32'(resp_valid), 32'd1);
        chk(resp_rdata === exp, req, resp_rdata, exp);
    endtask

    function automatic logic [NCPU-1:0] model_irq(input logic [NCPU-1:0] cur, input logic [15:0] a,
                                                   input logic [3:0] be, input logic [31:0] d);
        logic [NCPU-1:0] n = cur;
        if (a[5:2] == 4'd2 && be[0] && d[7:0] < NCPU)
            n[d[7:0]] = be[1] && (d[15:8] != 0);
        return n;
    endfunction

    task automatic irq_wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d, input string req);
        exp_irq = model_irq(exp_irq, a, be, d);
        wr(a, be, d);
        chk(irq_out === exp_irq, req, 32'(irq_out), 32'(exp_irq));
        chk(halt_strobe === 1'b0, "R9 no halt from irq/undecoded write", 32'(halt_strobe), 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(irq_out === '0, "R1 irq after reset", 32'(irq_out), 32'd0);
        chk(halt_strobe === 1'b0, "R1 halt after reset", 32'(halt_strobe), 32'd0);
        chk(resp_valid === 1'b0, "R1 resp after reset", 32'(resp_valid), 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(irq_out === '0 && !halt_strobe && !resp_valid, "R1 idle after release", 32'(irq_out), 32'd0);

        // R4 count, default configuration returns 1
        rd_chk(16'h000C, 8'h00, 32'd1, "R4 processor count");
        // R3 requester ID sweep, with R8 aliases
        for (int i = 0; i < 8; i++) begin
            rd_chk(16'h0004, 8'(i), 32'(i), "R3 requester id");
            rd_chk(16'h0004 + 16'(64 * (i + 1)), 8'(8'hA0 + i), 32'(8'hA0 + i), "R8 id alias");
        end
        rd_chk(16'hFFC7, 8'h3C, 32'h3C, "R8 id alias high with low addr bits");

        // R9 read sweep over all 16 word indices
        for (int w = 0; w < 16; w++) begin
            logic [31:0] e;
            e = (w == 1) ? 32'h5A : (w == 3) ? 32'd1 : 32'd0;
            rd_chk(16'(w * 4), 8'h5A, e, (w == 1 || w == 3) ? "R9 decoded read" : "R9 undecoded read zero");
        end

        // R10 back-to-back reads, then write gives no response
        req_valid = 1; req_write = 0; req_addr = 16'h0004; req_cpu_id = 8'h11;
        @(negedge clk);
        req_addr = 16'h000C; req_cpu_id = 8'h22;
        chk(resp_valid === 1'b1 && resp_rdata === 32'h11, "R10 first of pair", resp_rdata, 32'h11);
        @(negedge clk);
        idle_bus();
        chk(resp_valid === 1'b1 && resp_rdata === 32'd1, "R10 second of pair", resp_rdata, 32'd1);
        wr(16'h0030, 4'hF, 32'h0);
        chk(resp_valid === 1'b0, "R10 no response to write", 32'(resp_valid), 32'd0);

        // R5 two-byte sweep over lines and levels
        for (int k = 0; k < NCPU; k++)
            for (int l = 0; l < 3; l++) begin
                logic [7:0] lv;
                lv = (l == 0) ? 8'h01 : (l == 1) ? 8'h00 : 8'h80;
                irq_wr(16'h0008, 4'b0011, {16'h0, lv, 8'(k)}, "R5 two-byte irq write");
            end
        irq_wr(16'h0008, 4'b0011, 32'h0000_0100, "R5 set line 0");
        irq_wr(16'h0008, 4'b0011, 32'h0000_FF02, "R5 set line 2");
        irq_wr(16'h0048, 4'b1111, 32'hFFFF_0103, "R8 alias irq set line 3");

        // R6 one-byte store clears selected set line
        irq_wr(16'h0008, 4'b0001, 32'h0000_FF02, "R6 one-byte clears line 2");
        irq_wr(16'h0008, 4'b0001, 32'h0000_0100, "R6 one-byte clears line 0");
        irq_wr(16'h0008, 4'b0011, 32'h0000_0101, "R5 set line 1");

        // R7 out-of-range and lane0-off leave lines unchanged
        for (int k = NCPU; k < 12; k++)
            irq_wr(16'h0008, 4'b0011, {16'h0, 8'h01, 8'(k)}, "R7 index out of range");
        irq_wr(16'h0008, 4'b0011, 32'h0000_01FF, "R7 index 255");
        irq_wr(16'h0008, 4'b0010, 32'h0000_0003, "R7 lane0 disabled");
        irq_wr(16'h0008, 4'b0010, 32'h0000_0001, "R7 lane0 disabled no clear");

        // R9 writes to undecoded and read-only offsets
        for (int w = 0; w < 16; w++)
            if (w != 0 && w != 2)
                irq_wr(16'(w * 4), 4'hF, 32'h0101_0100, "R9 write ignored");

        // R2 halt strobes
        for (int s = 0; s < 3; s++) begin
            logic [7:0] st;
            st = (s == 0) ? 8'h00 : (s == 1) ? 8'h5A : 8'hFF;
            wr(16'h0000 + 16'(s * 64), 4'b0001, {24'h0, st});
            chk(halt_strobe === 1'b1, "R2 halt strobe high", 32'(halt_strobe), 32'd1);
            chk(halt_status === st, "R2 halt status", 32'(halt_status), 32'(st));
            @(negedge clk);
            chk(halt_strobe === 1'b0, "R2 halt strobe one cycle", 32'(halt_strobe), 32'd0);
        end
        wr(16'h0000, 4'b1110, 32'h0000_0033);
        chk(halt_strobe === 1'b0, "R2 no halt without lane0", 32'(halt_strobe), 32'd0);
        chk(irq_out === exp_irq, "R2 halt leaves irq", 32'(irq_out), 32'(exp_irq));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule